// File: doc/BRIEF.md
# Fractional Multiply-Accumulate ALU

This unit is the arithmetic core of an audio effects processor. It accepts one instruction per clock, qualified by a valid strobe. Each instruction has a 4-bit opcode and three 32-bit two's complement operands, named A, X and Y. One clock later the unit presents a 32-bit result, a 9-bit condition word and a 67-bit accumulator.

Products are read as Q31 fractions: the 64-bit product is shifted right by 31 places with sign extension. Each arithmetic opcode is either saturating or wrapping, and uses either the plain product or the negated product. The set also includes an integer multiply-add, a three-operand add, a move-and-accumulate, a masked XOR, three signed selects and a linear interpolation. Opcodes 0xC, 0xD and 0xF are placeholders. They pass A through and leave the accumulator alone.

All comparisons are signed. A saturating operation clamps to 0x7FFFFFFF or 0x80000000 and raises the saturate flag. Every executed opcode except move-and-accumulate and the placeholders reloads the accumulator with the full-precision value of that instruction.

Top module: `dsp_mac_alu`

## Requirements
- R1: Opcode 0x0 gives A + floor(X*Y / 2^31). Opcode 0x1 gives A + floor(-(X*Y) / 2^31). Both clamp to 0x7FFFFFFF or 0x80000000 when the exact sum leaves the signed 32-bit range.
- R2: Opcodes 0x2 and 0x3 compute the same sums as 0x0 and 0x1 but return the low 32 bits of the exact sum.
- R3: Opcode 0x4 gives A + X*Y, an unshifted integer product, with clamping. Opcode 0x5 takes bits 30:0 of the same exact sum and sign-extends them from bit 30.
- R4: Opcode 0x6 gives A + X + Y with clamping.
- R5: Opcode 0x7 returns A and adds floor(X*Y / 2^31) into the 67-bit accumulator, which wraps modulo 2^67.
- R6: Opcode 0x8 returns (A AND X) XOR Y.
- R7: The selects use signed A and Y. Opcode 0x9 returns X when A >= Y and NOT X otherwise. Opcode 0xA returns X when A >= Y and Y otherwise. Opcode 0xB returns X when A < Y and Y otherwise.
- R8: Opcode 0xE gives A + floor(X*(Y-A) / 2^31), with the difference Y-A taken at full precision, and clamps the sum.
- R9: Opcodes 0xC, 0xD and 0xF return A, and the accumulator keeps its value.
- R10: The condition word is computed from each result. Bit 0 is set when result bits 31 and 30 differ. Bit 1 is set when a select opcode (0x9 to 0xB) finds A < Y. Bit 2 equals result bit 31. Bit 3 is set when the result is zero. Bit 4 is set when a clamp occurred. Bit 8 is set when the result is non-zero. Bits 7:5 are zero.
- R11: Every other opcode loads the accumulator with its exact sum. Opcodes 0x0 to 0x6 and 0xE load the unclamped, unwrapped sum. Opcodes 0x8 to 0xB load the result sign-extended to 67 bits.
- R12: Results appear on the clock edge after the one that captures valid_i, with res_valid_o high for exactly that cycle. While valid_i is low, the result, condition word and accumulator hold their values. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 4 | Opcode |
| a_i | input | 32 | Operand A |
| x_i | input | 32 | Operand X |
| y_i | input | 32 | Operand Y |
| res_o | output | 32 | Result R |
| res_valid_o | output | 1 | Result updated this cycle |
| ccr_o | output | 9 | Condition word |
| acc_o | output | 67 | Accumulator |

## Verification
Two things share a single clock edge in this unit: the result and condition word are written from one datapath, while the accumulator is written from a different source. Under move-and-accumulate the result is A, yet the accumulator takes in a product. Under every other arithmetic opcode the accumulator takes the unclamped sum, even in the cycle where the result is clamped. The bench provokes both cases. It runs runs of move-and-accumulate on full-scale operands and places saturating corners directly after them. The scoreboard then compares the result, the flags and the 67-bit accumulator of each item separately against a model that keeps its own accumulator.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;
  typedef enum logic [3:0] {
    OP_MACS   = 4'h0,
    OP_MACNS  = 4'h1,
    OP_MACW   = 4'h2,
    OP_MACNW  = 4'h3,
    OP_IMACS  = 4'h4,
    OP_IMACW  = 4'h5,
    OP_ADD3S  = 4'h6,
    OP_MOVACC = 4'h7,
    OP_ANDXOR = 4'h8,
    OP_TSTNEG = 4'h9,
    OP_LIMGE  = 4'hA,
    OP_LIMLT  = 4'hB,
    OP_RSV_C  = 4'hC,
    OP_RSV_D  = 4'hD,
    OP_INTERP = 4'hE,
    OP_RSV_F  = 4'hF
  } op_e;

  localparam int CCR_W      = 9;
  localparam int FLG_NORM   = 0;
  localparam int FLG_BORROW = 1;
  localparam int FLG_MINUS  = 2;
  localparam int FLG_ZERO   = 3;
  localparam int FLG_SAT    = 4;
  localparam int FLG_NZ     = 8;
endpackage

// File: rtl/dsp_mac_mul.sv
module dsp_mac_mul
  import dsp_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int MUL_W = 2 * DATA_W + 1
) (
  input  op_e                      op_i,
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        x_i,
  input  logic [DATA_W-1:0]        y_i,
  output logic signed [MUL_W-1:0]  prod_o,
  output logic signed [MUL_W-1:0]  frac_o
);
  localparam int FRAC_SH = DATA_W - 1;
  localparam int XE_W    = MUL_W - DATA_W;
  localparam int BE_W    = MUL_W - DATA_W - 1;

  logic signed [DATA_W:0]    mb;
  logic signed [MUL_W-1:0]   xe, be, prod, pn;
  logic                      neg;

  // one multiplier shared between X*Y and X*(Y-A)
  always_comb begin
    if (op_i == OP_INTERP) mb = {y_i[DATA_W-1], y_i} - {a_i[DATA_W-1], a_i};
    else                   mb = {y_i[DATA_W-1], y_i};
  end

  assign xe   = {{XE_W{x_i[DATA_W-1]}}, x_i};
  assign be   = {{BE_W{mb[DATA_W]}}, mb};
  assign prod = xe * be;
  assign neg  = (op_i == OP_MACNS) || (op_i == OP_MACNW);
  assign pn   = neg ? -prod : prod;

  assign prod_o = prod;
  assign frac_o = pn >>> FRAC_SH;
endmodule

// File: rtl/dsp_mac_sat.sv
module dsp_mac_sat #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 67
) (
  input  logic signed [ACC_W-1:0] sum_i,
  input  logic                    sat_en_i,
  input  logic                    wrap31_i,
  output logic [DATA_W-1:0]       res_o,
  output logic                    clamp_o
);
  localparam int HI_W = ACC_W - DATA_W + 1;
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic [HI_W-1:0] hi;
  logic            fits;

  assign hi      = sum_i[ACC_W-1:DATA_W-1];
  assign fits    = (&hi) | ~(|hi);
  assign clamp_o = sat_en_i & ~fits;

  always_comb begin
    if (clamp_o)       res_o = sum_i[ACC_W-1] ? MIN_V : MAX_V;
    else if (wrap31_i) res_o = {sum_i[DATA_W-2], sum_i[DATA_W-2:0]};
    else               res_o = sum_i[DATA_W-1:0];
  end
endmodule

// File: rtl/dsp_mac_logic.sv
module dsp_mac_logic
  import dsp_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] res_o,
  output logic              borrow_o
);
  logic lt;
  assign lt = $signed(a_i) < $signed(y_i);

  always_comb begin
    borrow_o = 1'b0;
    unique case (op_i)
      OP_ANDXOR: res_o = (a_i & x_i) ^ y_i;
      OP_TSTNEG: begin res_o = lt ? ~x_i : x_i; borrow_o = lt; end
      OP_LIMGE:  begin res_o = lt ? y_i : x_i;  borrow_o = lt; end
      OP_LIMLT:  begin res_o = lt ? x_i : y_i;  borrow_o = lt; end
      default:   res_o = a_i;
    endcase
  end
endmodule

// File: rtl/dsp_mac_alu.sv
module dsp_mac_alu
  import dsp_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 67
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o,
  output logic [CCR_W-1:0]  ccr_o,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int MUL_W = 2 * DATA_W + 1;
  localparam int AX_W  = ACC_W - DATA_W;
  localparam int MX_W  = ACC_W - MUL_W;

  op_e op;
  assign op = op_e'(op_i);

  logic signed [MUL_W-1:0] prod, frac;
  logic signed [ACC_W-1:0] a_ext, x_ext, y_ext, frac_ext, addend, sum;
  logic [DATA_W-1:0]       arith_r, logic_r, r_nx;
  logic [ACC_W-1:0]        acc_nx, acc_q;
  logic [CCR_W-1:0]        f_nx, ccr_q;
  logic [DATA_W-1:0]       r_q;
  logic                    v_q;
  logic                    sat_en, wrap31, clamp, borrow, is_arith;

  dsp_mac_mul #(.DATA_W(DATA_W)) u_mul (
    .op_i(op), .a_i(a_i), .x_i(x_i), .y_i(y_i), .prod_o(prod), .frac_o(frac)
  );

  dsp_mac_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i(op), .a_i(a_i), .x_i(x_i), .y_i(y_i), .res_o(logic_r), .borrow_o(borrow)
  );

  assign a_ext    = {{AX_W{a_i[DATA_W-1]}}, a_i};
  assign x_ext    = {{AX_W{x_i[DATA_W-1]}}, x_i};
  assign y_ext    = {{AX_W{y_i[DATA_W-1]}}, y_i};
  assign frac_ext = {{MX_W{frac[MUL_W-1]}}, frac};

  always_comb begin
    addend   = '0;
    is_arith = 1'b1;
    unique case (op)
      OP_MACS, OP_MACNS, OP_MACW, OP_MACNW, OP_INTERP: addend = frac_ext;
      OP_IMACS, OP_IMACW: addend = {{MX_W{prod[MUL_W-1]}}, prod};
      OP_ADD3S:           addend = x_ext + y_ext;
      default:            is_arith = 1'b0;
    endcase
  end

  assign sum    = a_ext + addend;
  assign sat_en = (op == OP_MACS) || (op == OP_MACNS) || (op == OP_IMACS) ||
                  (op == OP_ADD3S) || (op == OP_INTERP);
  assign wrap31 = (op == OP_IMACW);

  dsp_mac_sat #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_sat (
    .sum_i(sum), .sat_en_i(sat_en), .wrap31_i(wrap31), .res_o(arith_r), .clamp_o(clamp)
  );

  always_comb begin
    if (is_arith) begin
      r_nx   = arith_r;
      acc_nx = sum;
    end else if (op == OP_MOVACC) begin
      r_nx   = a_i;
      acc_nx = acc_q + frac_ext;
    end else if (op == OP_RSV_C || op == OP_RSV_D || op == OP_RSV_F) begin
      r_nx   = a_i;
      acc_nx = acc_q;
    end else begin
      r_nx   = logic_r;
      acc_nx = {{AX_W{logic_r[DATA_W-1]}}, logic_r};
    end
  end

  always_comb begin
    f_nx             = '0;
    f_nx[FLG_NORM]   = r_nx[DATA_W-1] ^ r_nx[DATA_W-2];
    f_nx[FLG_BORROW] = borrow;
    f_nx[FLG_MINUS]  = r_nx[DATA_W-1];
    f_nx[FLG_ZERO]   = ~(|r_nx);
    f_nx[FLG_SAT]    = clamp;
    f_nx[FLG_NZ]     = |r_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q   <= '0;
      ccr_q <= '0;
      acc_q <= '0;
      v_q   <= 1'b0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        r_q   <= r_nx;
        ccr_q <= f_nx;
        acc_q <= acc_nx;
      end
    end
  end

  assign res_o       = r_q;
  assign res_valid_o = v_q;
  assign ccr_o       = ccr_q;
  assign acc_o       = acc_q;
endmodule

// File: rtl/dsp_mac_alu_chk.sv
module dsp_mac_alu_chk #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 67
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] res_o,
  input logic              res_valid_o,
  input logic [8:0]        ccr_o,
  input logic [ACC_W-1:0]  acc_o
);
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  assert_valid_follows_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_valid_o);

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_valid_o && $stable(res_o) && $stable(ccr_o) && $stable(acc_o));

  assert_zero_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (ccr_o[3] == (res_o == '0)) && (ccr_o[8] != ccr_o[3]));

  assert_minus_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ccr_o[2] == res_o[DATA_W-1]);

  assert_spare_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccr_o[7:5] == 3'b000);

  assert_clamp_value_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && ccr_o[4]) |-> (res_o == MAX_V) || (res_o == MIN_V));

  assert_movacc_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'h7) |=> res_o == $past(a_i));

  assert_rsv_untouched_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'hC || op_i == 4'hD || op_i == 4'hF))
      |=> (res_o == $past(a_i)) && (acc_o == $past(acc_o)));
endmodule

bind dsp_mac_alu dsp_mac_alu_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .a_i(a_i),
  .res_o(res_o), .res_valid_o(res_valid_o), .ccr_o(ccr_o), .acc_o(acc_o)
);

// File: tb/sim_dsp_mac_alu.sv
module sim_dsp_mac_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, x_i = '0, y_i = '0;
  logic [31:0] res_o;
  logic        res_valid_o;
  logic [8:0]  ccr_o;
  logic [66:0] acc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] r;
    logic [8:0]  f;
    logic [66:0] acc;
    string       tag;
    string       acc_tag;
  } exp_t;
  exp_t sb_q[$];

  logic [66:0] m_acc = '0;
  logic [31:0] last_r = '0;
  logic [8:0]  last_f = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_mac_alu u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .x_i(x_i), .y_i(y_i), .res_o(res_o), .res_valid_o(res_valid_o),
    .ccr_o(ccr_o), .acc_o(acc_o)
  );

  task automatic chk(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h0, 4'h1: return "R1";
      4'h2, 4'h3: return "R2";
      4'h4, 4'h5: return "R3";
      4'h6:       return "R4";
      4'h7:       return "R5";
      4'h8:       return "R6";
      4'h9, 4'hA, 4'hB: return "R7";
      4'hE:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  // reference model at 128-bit precision
  task automatic ref_model(input logic [3:0] op, input logic [31:0] a, x, y,
                           output logic [31:0] r, output logic [8:0] f);
    logic signed [127:0] sa, sx, sy, p, s;
    bit clamp = 0, brw = 0, arith = 0, keep = 0;
    sa = {{96{a[31]}}, a};
    sx = {{96{x[31]}}, x};
    sy = {{96{y[31]}}, y};
    s  = '0;
    r  = a;
    case (op)
      4'h0, 4'h1, 4'h2, 4'h3: begin
        p = sx * sy;
        if (op[0]) p = -p;
        s = sa + (p >>> 31); arith = 1;
      end
      4'h4, 4'h5: begin s = sa + sx * sy; arith = 1; end
      4'h6: begin s = sa + sx + sy; arith = 1; end
      4'hE: begin p = sx * (sy - sa); s = sa + (p >>> 31); arith = 1; end
      4'h7: begin p = (sx * sy) >>> 31; m_acc = m_acc + p[66:0]; keep = 1; end
      4'h8: r = (a & x) ^ y;
      4'h9: begin brw = sa < sy; r = brw ? ~x : x; end
      4'hA: begin brw = sa < sy; r = brw ? y : x; end
      4'hB: begin brw = sa < sy; r = brw ? x : y; end
      default: keep = 1;
    endcase
    if (arith) begin
      if ((op == 4'h0 || op == 4'h1 || op == 4'h4 || op == 4'h6 || op == 4'hE) &&
          s > 128'sd2147483647) begin r = 32'h7FFF_FFFF; clamp = 1; end
      else if ((op == 4'h0 || op == 4'h1 || op == 4'h4 || op == 4'h6 || op == 4'hE) &&
          s < -128'sd2147483648) begin r = 32'h8000_0000; clamp = 1; end
      else if (op == 4'h5) r = {s[30], s[30:0]};
      else r = s[31:0];
      m_acc = s[66:0];
    end else if (!keep) begin
      m_acc = {{35{r[31]}}, r};
    end
    f = '0;
    f[0] = r[31] ^ r[30];
    f[1] = brw;
    f[2] = r[31];
    f[3] = (r == 32'h0);
    f[4] = clamp;
    f[8] = (r != 32'h0);
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, x, y);
    exp_t e;
    logic [31:0] r;
    logic [8:0]  f;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; a_i = a; x_i = x; y_i = y;
    ref_model(op, a, x, y, r, f);
    e.r = r; e.f = f; e.acc = m_acc; e.tag = tag_of(op);
    e.acc_tag = (op == 4'h7) ? "R5" : (e.tag == "R9") ? "R9" : "R11";
    last_r = r; last_f = f;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      a_i = $urandom; x_i = $urandom; y_i = $urandom; op_i = 4'($urandom);
    end
  endtask

  // monitor
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_ni && res_valid_o) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R12", "result with empty scoreboard act=1 exp=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(res_o == e.r, e.tag, $sformatf("result act=%h exp=%h", res_o, e.r));
        chk(ccr_o == e.f, "R10", $sformatf("flags act=%h exp=%h", ccr_o, e.f));
        chk(acc_o == e.acc, e.acc_tag, $sformatf("acc act=%h exp=%h", acc_o, e.acc));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] cv [7];
    cv[0] = 32'h0000_0000; cv[1] = 32'h0000_0001; cv[2] = 32'h7FFF_FFFF;
    cv[3] = 32'h8000_0000; cv[4] = 32'hFFFF_FFFF; cv[5] = 32'h4000_0000;
    cv[6] = 32'hC000_0000;

    repeat (3) @(posedge clk);
    #1;
    chk(res_o == 32'h0 && ccr_o == 9'h0 && acc_o == 67'h0 && !res_valid_o, "R12",
        $sformatf("reset act=%h/%h/%h exp=0", res_o, ccr_o, acc_o));
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 R2: full-scale squares, plain and negated
    issue(4'h0, 32'h0, 32'h8000_0000, 32'h8000_0000);
    issue(4'h1, 32'h0, 32'h8000_0000, 32'h8000_0000);
    issue(4'h2, 32'h0, 32'h8000_0000, 32'h8000_0000);
    issue(4'h3, 32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF);

    // R5: run of move-and-accumulate beyond 32 bits, then clamps in the next cycle
    for (int i = 0; i < 12; i++) issue(4'h7, $urandom, 32'h8000_0000, 32'h8000_0000);
    issue(4'hC, 32'h1234_5678, $urandom, $urandom);
    issue(4'h0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    for (int i = 0; i < 4; i++) issue(4'h7, $urandom, 32'h8000_0000, 32'h7FFF_FFFF);
    issue(4'h6, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF);

    // R12: hold while idle
    idle(4);
    #(CLK_PERIOD/4);
    chk(res_o == last_r && ccr_o == last_f && acc_o == m_acc && !res_valid_o, "R12",
        $sformatf("hold act=%h exp=%h", res_o, last_r));

    // corner sweep over all opcodes
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          for (int k = 0; k < 7; k++)
            issue(4'(op), cv[i], cv[j], cv[k]);

    // random traffic with gaps
    for (int n = 0; n < 3000; n++) begin
      issue(4'($urandom), $urandom, $urandom, $urandom);
      if ($urandom_range(0, 3) == 0) idle(1);
    end

    idle(3);
    #(CLK_PERIOD/4);
    chk(sb_q.size() == 0, "R12", $sformatf("pending act=%0d exp=0", sb_q.size()));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule